// File: doc/BRIEF.md
# Multiplexed Latched Display Scanner

This block turns a six-digit BCD count into the signals for a time-multiplexed numeric display. The count passes through a set of output latches that follow it while a transfer control is high and freeze it while that control is low. The display keeps showing a stable reading while the count moves on.

A scan sequencer walks through the digits, most significant first. It advances one step on each pulse of a scan-clock enable. For each digit it presents the BCD nibble and the matching seven-segment pattern, and raises that digit's select line only in the middle of the digit's slot. The data are therefore settled before the select rises and stay put until after it falls.

Leading zeros are blanked on the segment outputs, and the least significant digit is always shown. Any digit can be forced visible by feeding its select line back to the blanking-override input. A lamp-test input lights every segment without disturbing the BCD outputs.

Top module: `digit_scan_display`

## Requirements
- R1: While `rst_n` is low and until the first scan step, `dig_sel`, `bcd_out` and `seg_out` are all zero, and the latched count is zero.
- R2: On a clock where `xfer_en` is high, the latches take `count_in`. While it is low they keep their value, so later changes of `count_in` never reach `bcd_out` or `seg_out`.
- R3: `dig_sel` is one-hot or zero. Digit p drives `dig_sel[p]`, where p=0 is the least significant digit. Slots run p=5,4,3,2,1,0 and then wrap to 5. A slot lasts 4 `scan_tick` pulses. Without `scan_tick` pulses the scan stands still.
- R4: A select is high only during the 2nd and 3rd tick periods of its slot. `bcd_out` and `seg_out` change only while every select is low, at least one clock before a select rises and one clock after it falls.
- R5: During digit p's slot, `bcd_out` equals `count_in[4p+3:4p]` as latched.
- R6: `seg_out` is active high with bit 0 = a through bit 6 = g. It uses the common patterns 0..9, which are 3F,06,5B,4F,66,6D,7D,07,7F,6F in hex. Codes 10..15 give 00.
- R7: A zero digit is blanked (`seg_out`=00) when every more significant digit is also a blanked zero. Digit 0 is never blanked. `bcd_out` still shows 0 for a blanked digit.
- R8: If `blank_override` is high at any clock of digit p's slot, digit p is shown from the next scan pass on, even if it is a leading zero. It also ends the leading-zero run, so the zeros below it are shown too. After a pass in which it stays low, p is blanked again.
- R9: While `lamp_test` is high, every digit presented shows `seg_out`=7F. `bcd_out` keeps the true digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_in | input | 24 | Six BCD digits, digit p in bits 4p+3..4p |
| xfer_en | input | 1 | High: latches follow the count; low: hold |
| scan_tick | input | 1 | One-clock scan step enable |
| blank_override | input | 1 | Forces the digit of the current slot to show |
| lamp_test | input | 1 | Lights all segments |
| dig_sel | output | 6 | One-hot active-high digit select |
| bcd_out | output | 4 | BCD nibble of the presented digit |
| seg_out | output | 7 | Segments a..g in bits 0..6 |

## Verification
The latches take a new count one clock after the transfer control. A digit's data are loaded into the output register only during the first tick period of its slot, so a new count, a lamp-test change or a blanking change reaches the outputs at the next slot start of each digit. That is at most one scan pass later. An override is applied on the pass after the one in which it was seen. The bench therefore waits at least one full pass after each stimulus (two or three for the override) before it captures a frame. It samples a digit only on falling clock edges while that digit's select is the single high line, which is the stable window. Ordering, and the rule that data change only while every select is low, are watched on every clock by monitors.

// File: rtl/dscan_pkg.sv
package dscan_pkg;

    localparam int BCD_W = 4;
    localparam int SEG_W = 7;

    // Active-high segments, bit 0 = a ... bit 6 = g; non-decimal codes dark.
    function automatic logic [SEG_W-1:0] bcd_to_seg(input logic [BCD_W-1:0] v);
        logic [SEG_W-1:0] s;
        case (v)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dscan_seq.sv
// Scan sequencer: digit position counts down from MSD to LSD, each slot
// split into SLOT_TICKS phases advanced by the scan enable (R3).
module dscan_seq #(
    parameter int NUM_DIGITS = 6,
    parameter int SLOT_TICKS = 4,
    localparam int POS_W = $clog2(NUM_DIGITS),
    localparam int PH_W  = $clog2(SLOT_TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [POS_W-1:0] pos_o,
    output logic [PH_W-1:0]  phase_o,
    output logic             slot_done_o
);

    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(SLOT_TICKS - 1);
    localparam logic [POS_W-1:0] POS_MSD = POS_W'(NUM_DIGITS - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [PH_W-1:0]  phase;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick_i) begin
            if (s_q.phase == PH_LAST) begin
                s_d.phase = '0;
                s_d.pos   = (s_q.pos == '0) ? POS_MSD : s_q.pos - 1'b1;
            end else begin
                s_d.phase = s_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.pos   <= POS_MSD;
            s_q.phase <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pos_o       = s_q.pos;
    assign phase_o     = s_q.phase;
    assign slot_done_o = tick_i && (s_q.phase == PH_LAST);

endmodule

// File: rtl/dscan_latch.sv
// Transfer latch: follows the count while enabled, holds otherwise (R2).
module dscan_latch #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (xfer_i) begin
            hold_d = d_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign q_o = hold_q;

endmodule

// File: rtl/dscan_blank.sv
// Blanking control: per-digit override memory captured once per slot, and
// the leading-zero chain evaluated from MSD downward (R7, R8).
module dscan_blank #(
    parameter int NUM_DIGITS = 6,
    localparam int POS_W = $clog2(NUM_DIGITS),
    localparam int CNT_W = NUM_DIGITS * 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNT_W-1:0]      digits_i,
    input  logic [POS_W-1:0]      pos_i,
    input  logic                  ovr_i,
    input  logic                  slot_done_i,
    output logic [NUM_DIGITS-1:0] blank_o
);

    typedef struct packed {
        logic [NUM_DIGITS-1:0] mask;
        logic                  seen;
    } blk_t;

    blk_t b_d, b_q;
    logic [NUM_DIGITS-1:0] zero_w;

    genvar g;
    generate
        for (g = 0; g < NUM_DIGITS; g++) begin : g_zero
            assign zero_w[g] = (digits_i[g*4 +: 4] == 4'd0);
        end
    endgenerate

    always_comb begin
        b_d      = b_q;
        b_d.seen = b_q.seen | ovr_i;
        if (slot_done_i) begin
            b_d.mask[pos_i] = b_q.seen | ovr_i;
            b_d.seen        = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    always_comb begin
        logic lead;
        lead    = 1'b1;
        blank_o = '0;
        for (int p = NUM_DIGITS - 1; p >= 0; p--) begin
            lead       = lead && zero_w[p] && !b_q.mask[p];
            blank_o[p] = lead && (p != 0);
        end
    end

endmodule

// File: rtl/digit_scan_display.sv
// Top: latches, sequencer, blanking and the registered output stage.
module digit_scan_display #(
    parameter int NUM_DIGITS  = 6,
    parameter int SLOT_TICKS  = 4,
    parameter int GUARD_TICKS = 1,
    localparam int CNT_W = NUM_DIGITS * 4,
    localparam int SEG_W = dscan_pkg::SEG_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNT_W-1:0]      count_in,
    input  logic                  xfer_en,
    input  logic                  scan_tick,
    input  logic                  blank_override,
    input  logic                  lamp_test,
    output logic [NUM_DIGITS-1:0] dig_sel,
    output logic [3:0]            bcd_out,
    output logic [SEG_W-1:0]      seg_out
);

    localparam int POS_W = $clog2(NUM_DIGITS);
    localparam int PH_W  = $clog2(SLOT_TICKS);
    localparam logic [PH_W-1:0] SEL_FIRST = PH_W'(GUARD_TICKS);
    localparam logic [PH_W-1:0] SEL_LAST  = PH_W'(SLOT_TICKS - 1 - GUARD_TICKS);

    typedef struct packed {
        logic [NUM_DIGITS-1:0] sel;
        logic [3:0]            bcd;
        logic [SEG_W-1:0]      seg;
    } out_t;

    logic [CNT_W-1:0]      latched_w;
    logic [POS_W-1:0]      pos_w;
    logic [PH_W-1:0]       phase_w;
    logic                  slot_done_w;
    logic [NUM_DIGITS-1:0] blank_w;
    logic [3:0]            digit_w [NUM_DIGITS];
    out_t                  o_d, o_q;

    dscan_latch #(.WIDTH(CNT_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .xfer_i (xfer_en),
        .d_i    (count_in),
        .q_o    (latched_w)
    );

    dscan_seq #(.NUM_DIGITS(NUM_DIGITS), .SLOT_TICKS(SLOT_TICKS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (scan_tick),
        .pos_o       (pos_w),
        .phase_o     (phase_w),
        .slot_done_o (slot_done_w)
    );

    dscan_blank #(.NUM_DIGITS(NUM_DIGITS)) u_blank (
        .clk         (clk),
        .rst_n       (rst_n),
        .digits_i    (latched_w),
        .pos_i       (pos_w),
        .ovr_i       (blank_override),
        .slot_done_i (slot_done_w),
        .blank_o     (blank_w)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_DIGITS; g++) begin : g_digit
            assign digit_w[g] = latched_w[g*4 +: 4];
        end
    endgenerate

    // Data reload only in the first phase of a slot; the select window sits
    // strictly inside the remaining phases, giving the guard band (R4).
    always_comb begin
        o_d = o_q;
        if (phase_w == '0) begin
            o_d.bcd = digit_w[pos_w];
            if (lamp_test) begin
                o_d.seg = '1;
            end else if (blank_w[pos_w]) begin
                o_d.seg = '0;
            end else begin
                o_d.seg = dscan_pkg::bcd_to_seg(digit_w[pos_w]);
            end
        end
        if (phase_w >= SEL_FIRST && phase_w <= SEL_LAST) begin
            o_d.sel = NUM_DIGITS'(1) << pos_w;
        end else begin
            o_d.sel = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign dig_sel = o_q.sel;
    assign bcd_out = o_q.bcd;
    assign seg_out = o_q.seg;

endmodule

// File: rtl/dscan_chk.sv
module dscan_chk #(
    parameter int NUM_DIGITS = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scan_tick,
    input logic [NUM_DIGITS-1:0] dig_sel,
    input logic [3:0]            bcd_out,
    input logic [6:0]            seg_out
);

    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_sel));

    p_sel_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dig_sel) |-> $past(scan_tick, 2));

    p_data_stable_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dig_sel) || $fell(|dig_sel)) |-> ($stable(bcd_out) && $stable(seg_out)));

    p_lsd_shown_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_sel[0] && bcd_out <= 4'd9) |-> (seg_out != 7'h00));

    p_nonzero_shown_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dig_sel) && bcd_out != 4'd0 && bcd_out <= 4'd9) |-> (seg_out != 7'h00));

endmodule

bind digit_scan_display dscan_chk #(.NUM_DIGITS(NUM_DIGITS)) u_dscan_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_tick (scan_tick),
    .dig_sel   (dig_sel),
    .bcd_out   (bcd_out),
    .seg_out   (seg_out)
);

// File: tb/digit_scan_display_bench.sv
`timescale 1ns/1ps
module digit_scan_display_bench;

    localparam int FRAME = 6 * 4 * 2;   // cycles per pass at one tick per two clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] count_in = '0;
    logic        xfer_en = 1'b0;
    logic        scan_tick = 1'b0;
    logic        lamp_test = 1'b0;
    logic        fb_en = 1'b0;
    logic [5:0]  dig_sel;
    logic [3:0]  bcd_out;
    logic [6:0]  seg_out;
    logic        blank_override;
    int          tick_mode = 0;
    int          fb_idx = 3;

    int n_checks = 0;
    int n_errors = 0;
    int order_viol = 0;
    int guard_viol = 0;

    logic [3:0] cap_bcd [6];
    logic [6:0] cap_seg [6];

    assign blank_override = fb_en ? dig_sel[fb_idx] : 1'b0;

    always #2 clk = ~clk;

    digit_scan_display u_digit_scan_display (
        .clk            (clk),
        .rst_n          (rst_n),
        .count_in       (count_in),
        .xfer_en        (xfer_en),
        .scan_tick      (scan_tick),
        .blank_override (blank_override),
        .lamp_test      (lamp_test),
        .dig_sel        (dig_sel),
        .bcd_out        (bcd_out),
        .seg_out        (seg_out)
    );

    always @(negedge clk) begin
        if (!rst_n) scan_tick <= 1'b0;
        else case (tick_mode)
            1:       scan_tick <= 1'b1;
            2:       scan_tick <= ~scan_tick;
            default: scan_tick <= 1'b0;
        endcase
    end

    // Monitors: scan order (R3) and data stability around selects (R4).
    logic [5:0] last_nz, prev_sel;
    logic [3:0] prev_bcd;
    logic [6:0] prev_seg;
    always @(negedge clk) begin
        if (!rst_n) begin
            last_nz  <= '0;
            prev_sel <= '0;
            prev_bcd <= '0;
            prev_seg <= '0;
        end else begin
            if (!$onehot0(dig_sel)) order_viol++;
            if (dig_sel != 6'd0 && dig_sel != last_nz) begin
                if (last_nz != 6'd0 &&
                    dig_sel != ((last_nz == 6'b000001) ? 6'b100000 : (last_nz >> 1)))
                    order_viol++;
                last_nz <= dig_sel;
            end
            if ((bcd_out != prev_bcd || seg_out != prev_seg) &&
                (dig_sel != 6'd0 || prev_sel != 6'd0))
                guard_viol++;
            prev_sel <= dig_sel;
            prev_bcd <= bcd_out;
            prev_seg <= seg_out;
        end
    end

    function automatic logic [6:0] ref_seg(input logic [3:0] v);
        case (v)
            4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
            4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
            4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
            4'd9: return 7'h6F;  default: return 7'h00;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic capture();
        bit got [6];
        int spin = 0;
        foreach (got[i]) got[i] = 1'b0;
        while (!(got[0] && got[1] && got[2] && got[3] && got[4] && got[5]) && spin < 2000) begin
            @(negedge clk);
            spin++;
            if ($onehot(dig_sel)) begin
                for (int p = 0; p < 6; p++) begin
                    if (dig_sel[p]) begin
                        cap_bcd[p] = bcd_out;
                        cap_seg[p] = seg_out;
                        got[p] = 1'b1;
                    end
                end
            end
        end
        chk(spin < 2000, "R3 full pass seen", spin, 0);
    endtask

    // Expected frame from the requirements: value, override mask, lamp test.
    task automatic check_frame(input logic [23:0] val, input logic [5:0] ovr,
                               input bit lamp, input string tag);
        logic lead;
        logic [3:0] d;
        logic [6:0] es;
        lead = 1'b1;
        capture();
        for (int p = 5; p >= 0; p--) begin
            d    = val[p*4 +: 4];
            lead = lead && (d == 4'd0) && !ovr[p];
            if (lamp) es = 7'h7F;
            else if (lead && p != 0) es = 7'h00;
            else es = ref_seg(d);
            chk(cap_bcd[p] == d, $sformatf("%s bcd digit %0d", tag, p), cap_bcd[p], d);
            chk(cap_seg[p] == es, $sformatf("%s seg digit %0d", tag, p), cap_seg[p], es);
        end
    endtask

    task automatic load(input logic [23:0] v);
        count_in = v;
        xfer_en  = 1'b1;
        wait_cycles(2);
        wait_cycles(FRAME + 8);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick_mode = 0;
        wait_cycles(4);
        rst_n = 1'b1;
        wait_cycles(3);
        chk(dig_sel == 6'd0, "R1 sel after reset", dig_sel, 0);
        chk(bcd_out == 4'd0, "R1 bcd after reset", bcd_out, 0);
        chk(seg_out == 7'd0, "R1 seg after reset", seg_out, 0);
        tick_mode = 2;
        check_frame(24'h000000, 6'd0, 1'b0, "R1 latched zero, R7 lsd");
    endtask

    task automatic t_display();
        load(24'h123456);
        check_frame(24'h123456, 6'd0, 1'b0, "R5 R6 plain");
        load(24'h987065);
        check_frame(24'h987065, 6'd0, 1'b0, "R6 inner zero");
    endtask

    task automatic t_leading();
        load(24'h000042);
        check_frame(24'h000042, 6'd0, 1'b0, "R7 leading");
        load(24'h100203);
        check_frame(24'h100203, 6'd0, 1'b0, "R7 no inner blank");
        load(24'h0000A5);
        check_frame(24'h0000A5, 6'd0, 1'b0, "R6 non-decimal");
    endtask

    task automatic t_freeze();
        load(24'h314159);
        xfer_en = 1'b0;
        wait_cycles(1);
        count_in = 24'h271828;
        wait_cycles(2 * FRAME);
        check_frame(24'h314159, 6'd0, 1'b0, "R2 hold");
        load(24'h271828);
        check_frame(24'h271828, 6'd0, 1'b0, "R2 follow");
    endtask

    task automatic t_lamp();
        load(24'h000307);
        lamp_test = 1'b1;
        wait_cycles(FRAME + 8);
        check_frame(24'h000307, 6'd0, 1'b1, "R9 lamp");
        lamp_test = 1'b0;
        wait_cycles(FRAME + 8);
        check_frame(24'h000307, 6'd0, 1'b0, "R9 lamp off");
    endtask

    task automatic t_override();
        load(24'h000042);
        fb_idx = 3;
        fb_en  = 1'b1;
        wait_cycles(3 * FRAME);
        check_frame(24'h000042, 6'b001000, 1'b0, "R8 override on");
        fb_en = 1'b0;
        wait_cycles(3 * FRAME);
        check_frame(24'h000042, 6'd0, 1'b0, "R8 override off");
    endtask

    task automatic t_fast_and_hold();
        logic [5:0] s0;
        logic [3:0] b0;
        tick_mode = 1;
        load(24'h654321);
        check_frame(24'h654321, 6'd0, 1'b0, "R3 fast scan");
        tick_mode = 0;
        wait_cycles(5);
        s0 = dig_sel;
        b0 = bcd_out;
        wait_cycles(40);
        chk(dig_sel == s0, "R3 no tick holds select", dig_sel, s0);
        chk(bcd_out == b0, "R3 no tick holds data", bcd_out, b0);
        tick_mode = 2;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        t_reset();
        t_display();
        t_leading();
        t_freeze();
        t_lamp();
        t_override();
        t_fast_and_hold();
        chk(order_viol == 0, "R3 order monitor", order_viol, 0);
        chk(guard_viol == 0, "R4 guard monitor", guard_viol, 0);
        summary();
    end

endmodule